// File: doc/BRIEF.md
# DMA Request Descriptor Sequencer

This block accepts one DMA request descriptor at a time, decodes it, and runs it through a fixed series of phases. It first runs an optional semaphore step that gates the data movement. It then starts the data movement itself, followed by semaphore steps that follow the movement, and then an optional doorbell write. Last, it may push a response record and raise an interrupt pulse. The descriptor arrives as one packed word under a valid/ready handshake. Each phase is delegated to an outside unit (data mover, semaphore unit, doorbell writer) through a one-cycle start pulse and a one-cycle done pulse.

Before anything runs, the sequencer checks the descriptor. A descriptor with an illegal transfer type, or with more than one gating semaphore command, starts no phase. When a response was asked for, it still gets one, carrying an error code. The interrupt decision combines a per-descriptor force bit, gated by an enable input, with a policy that interrupts on response.

Top module: `dma_req_sequencer`

## Requirements
- R1: `desc_ready_o` is high only while idle. After a descriptor is accepted it stays low until that descriptor has fully retired, and then returns high.
- R2: Phases run in a fixed order, and each one waits for its done pulse before the next starts. The order is: the single gating semaphore command (slot enabled by bit 31 with bit 22 set); the data movement; each post semaphore command (bit 31 set, bit 22 clear) in slot order 0 to 3; the doorbell when attribute bit 7 is set. Start pulses are one cycle long and never overlap.
- R3: Command bits 1:0 select the transfer: 0 skips the data movement, 1 moves host to device, 2 moves device to host. The mover receives the type, the bulk flag (command bit 3, 1 = bulk, 0 = linked list), the source, the destination and the 32-bit length.
- R4: Transfer type 3 is illegal. Such a descriptor starts no phase, and its response code is 1.
- R5: More than one enabled gating semaphore command makes the descriptor illegal. It then starts no phase, and its response code is 2, unless R4 applies first.
- R6: When command bit 4 is set, one response record is pushed after the other phases. It carries the descriptor's request ID and code 0 on success. It is held stable until `resp_ready_i` takes it.
- R7: When command bit 4 is clear, no response record is pushed.
- R8: `msi_o` pulses for one cycle at retirement when command bit 7 is set and `force_msi_en_i` is high, or when a response was pushed and `resp_msi_en_i` is high. Otherwise it stays low.
- R9: The 8-bit sequence field and command bits 6, 5 and 2 have no effect on any output.
- R10: The doorbell writer receives the doorbell address, the data word, and the size code from attribute bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_i | input | DESC_W (424) | Packed descriptor |
| desc_ready_o | output | 1 | Sequencer idle, descriptor taken |
| force_msi_en_i | input | 1 | Honour the per-descriptor force-interrupt bit |
| resp_msi_en_i | input | 1 | Interrupt whenever a response is pushed |
| dma_start_o | output | 1 | Data movement start pulse |
| dma_dir_o | output | 2 | Transfer type |
| dma_bulk_o | output | 1 | 1 bulk, 0 linked list |
| dma_src_o | output | 64 | Source or list address |
| dma_dst_o | output | 64 | Destination address |
| dma_len_o | output | 32 | Byte length |
| dma_done_i | input | 1 | Data movement finished |
| sem_start_o | output | 1 | Semaphore command start pulse |
| sem_cmd_o | output | 32 | Semaphore command word |
| sem_done_i | input | 1 | Semaphore command finished |
| db_start_o | output | 1 | Doorbell write start pulse |
| db_addr_o | output | 64 | Doorbell address |
| db_data_o | output | 32 | Doorbell data |
| db_size_o | output | 2 | Doorbell size code |
| db_done_i | input | 1 | Doorbell write finished |
| resp_valid_o | output | 1 | Response record valid |
| resp_id_o | output | 16 | Request ID |
| resp_code_o | output | 16 | Completion code |
| resp_ready_i | input | 1 | Response queue takes the record |
| msi_o | output | 1 | Interrupt request pulse |

## Verification
The bench runs empty descriptors with no phases at all, and fully loaded ones with a gating command, all postsync slots and a doorbell. Comparing the observed start sequence with a model separates ordering faults from skipped or extra phases. Illegal transfer types and double gating commands, alone and combined, expose the check logic and the priority between the two error codes. Runs that differ only in the sequence and reserved bits, interrupt enables set both ways, and a stalled response queue isolate the interrupt decision, the response hold and the fields that must be ignored. Random descriptors with random done latencies cover the mixes in between.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam int ID_W   = 16;
  localparam int ADDR_W = 64;
  localparam int LEN_W  = 32;
  localparam int NSEM   = 4;
  localparam int SEM_W  = 32;
  localparam int CODE_W = 16;

  localparam int CMD_FORCE = 7;
  localparam int CMD_RESP  = 4;
  localparam int CMD_BULK  = 3;
  localparam int SEM_EN    = 31;
  localparam int SEM_PRE   = 22;
  localparam int BELL_EN   = 7;

  localparam logic [CODE_W-1:0] CC_OK        = 16'd0;
  localparam logic [CODE_W-1:0] CC_BAD_TYPE  = 16'd1;
  localparam logic [CODE_W-1:0] CC_MULTI_PRE = 16'd2;

  typedef struct packed {
    logic [ID_W-1:0]            rid;
    logic [7:0]                 seq;
    logic [7:0]                 cmd;
    logic [ADDR_W-1:0]          src;
    logic [ADDR_W-1:0]          dst;
    logic [LEN_W-1:0]           len;
    logic [ADDR_W-1:0]          bell_addr;
    logic [7:0]                 bell_attr;
    logic [31:0]                bell_data;
    logic [NSEM-1:0][SEM_W-1:0] sem;
  } dsq_desc_t;

  localparam int DESC_W = $bits(dsq_desc_t);

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHK, ST_PRE_GO, ST_PRE_WT, ST_DMA_GO, ST_DMA_WT,
    ST_POST, ST_POST_GO, ST_POST_WT, ST_BELL_GO, ST_BELL_WT,
    ST_RESP, ST_END
  } dsq_state_e;
endpackage

// File: rtl/dsq_decode.sv
module dsq_decode
  import dsq_pkg::*;
(
  input  dsq_desc_t          d_i,
  output logic               illegal_o,
  output logic [CODE_W-1:0]  code_o,
  output logic               has_pre_o,
  output logic [SEM_W-1:0]   pre_word_o,
  output logic [NSEM-1:0]    post_mask_o
);
  logic [NSEM-1:0] pre_mask;
  logic            bad_type, multi_pre;

  for (genvar k = 0; k < NSEM; k++) begin : g_slot
    assign pre_mask[k]    = d_i.sem[k][SEM_EN] &  d_i.sem[k][SEM_PRE];
    assign post_mask_o[k] = d_i.sem[k][SEM_EN] & ~d_i.sem[k][SEM_PRE];
  end

  always_comb begin
    pre_word_o = '0;
    for (int k = 0; k < NSEM; k++)
      if (pre_mask[k]) pre_word_o = pre_word_o | d_i.sem[k];
  end

  assign bad_type  = (d_i.cmd[1:0] == 2'd3);
  assign multi_pre = ($countones(pre_mask) > 1);
  assign has_pre_o = |pre_mask;
  assign illegal_o = bad_type | multi_pre;
  // type error outranks presync error
  assign code_o    = bad_type ? CC_BAD_TYPE : (multi_pre ? CC_MULTI_PRE : CC_OK);
endmodule

// File: rtl/dsq_msi_gate.sv
module dsq_msi_gate (
  input  logic retire_i,
  input  logic force_bit_i,
  input  logic force_en_i,
  input  logic resp_bit_i,
  input  logic resp_en_i,
  output logic msi_o
);
  assign msi_o = retire_i & ((force_bit_i & force_en_i) | (resp_bit_i & resp_en_i));
endmodule

// File: rtl/dma_req_sequencer.sv
module dma_req_sequencer
  import dsq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  desc_valid_i,
  input  logic [DESC_W-1:0]     desc_i,
  output logic                  desc_ready_o,
  input  logic                  force_msi_en_i,
  input  logic                  resp_msi_en_i,
  output logic                  dma_start_o,
  output logic [1:0]            dma_dir_o,
  output logic                  dma_bulk_o,
  output logic [ADDR_W-1:0]     dma_src_o,
  output logic [ADDR_W-1:0]     dma_dst_o,
  output logic [LEN_W-1:0]      dma_len_o,
  input  logic                  dma_done_i,
  output logic                  sem_start_o,
  output logic [SEM_W-1:0]      sem_cmd_o,
  input  logic                  sem_done_i,
  output logic                  db_start_o,
  output logic [ADDR_W-1:0]     db_addr_o,
  output logic [31:0]           db_data_o,
  output logic [1:0]            db_size_o,
  input  logic                  db_done_i,
  output logic                  resp_valid_o,
  output logic [ID_W-1:0]       resp_id_o,
  output logic [CODE_W-1:0]     resp_code_o,
  input  logic                  resp_ready_i,
  output logic                  msi_o
);
  localparam int SEL_W = (NSEM > 1) ? $clog2(NSEM) : 1;
  localparam int IDX_W = SEL_W + 1;

  dsq_state_e          st_q, st_d, tail;
  dsq_desc_t           d_q;
  logic [IDX_W-1:0]    idx_q;
  logic [SEL_W-1:0]    sel;
  logic                post_end, want_resp, bell_en, xfer_on;
  logic                illegal, has_pre;
  logic [CODE_W-1:0]   code;
  logic [SEM_W-1:0]    pre_word;
  logic [NSEM-1:0]     post_mask;

  dsq_decode u_decode (
    .d_i         (d_q),
    .illegal_o   (illegal),
    .code_o      (code),
    .has_pre_o   (has_pre),
    .pre_word_o  (pre_word),
    .post_mask_o (post_mask)
  );

  assign sel       = idx_q[SEL_W-1:0];
  assign post_end  = (idx_q == IDX_W'(NSEM));
  assign want_resp = d_q.cmd[CMD_RESP];
  assign bell_en   = d_q.bell_attr[BELL_EN];
  assign xfer_on   = (d_q.cmd[1:0] != 2'd0);
  assign tail      = want_resp ? ST_RESP : ST_END;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (desc_valid_i) st_d = ST_CHK;
      ST_CHK: begin
        if (illegal)      st_d = tail;
        else if (has_pre) st_d = ST_PRE_GO;
        else if (xfer_on) st_d = ST_DMA_GO;
        else              st_d = ST_POST;
      end
      ST_PRE_GO:  st_d = ST_PRE_WT;
      ST_PRE_WT:  if (sem_done_i) st_d = xfer_on ? ST_DMA_GO : ST_POST;
      ST_DMA_GO:  st_d = ST_DMA_WT;
      ST_DMA_WT:  if (dma_done_i) st_d = ST_POST;
      ST_POST: begin
        if (post_end)            st_d = bell_en ? ST_BELL_GO : tail;
        else if (post_mask[sel]) st_d = ST_POST_GO;
      end
      ST_POST_GO: st_d = ST_POST_WT;
      ST_POST_WT: if (sem_done_i) st_d = ST_POST;
      ST_BELL_GO: st_d = ST_BELL_WT;
      ST_BELL_WT: if (db_done_i) st_d = tail;
      ST_RESP:    if (resp_ready_i) st_d = ST_END;
      ST_END:     st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      d_q   <= '0;
      idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE) begin
        idx_q <= '0;
        if (desc_valid_i) d_q <= dsq_desc_t'(desc_i);
      end else if ((st_q == ST_POST && !post_end && !post_mask[sel]) ||
                   (st_q == ST_POST_WT && sem_done_i)) begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign desc_ready_o = (st_q == ST_IDLE);

  assign dma_start_o = (st_q == ST_DMA_GO);
  assign dma_dir_o   = d_q.cmd[1:0];
  assign dma_bulk_o  = d_q.cmd[CMD_BULK];
  assign dma_src_o   = d_q.src;
  assign dma_dst_o   = d_q.dst;
  assign dma_len_o   = d_q.len;

  assign sem_start_o = (st_q == ST_PRE_GO) || (st_q == ST_POST_GO);
  assign sem_cmd_o   = (st_q == ST_PRE_GO) ? pre_word : d_q.sem[sel];

  assign db_start_o = (st_q == ST_BELL_GO);
  assign db_addr_o  = d_q.bell_addr;
  assign db_data_o  = d_q.bell_data;
  assign db_size_o  = d_q.bell_attr[1:0];

  assign resp_valid_o = (st_q == ST_RESP);
  assign resp_id_o    = d_q.rid;
  assign resp_code_o  = code;

  dsq_msi_gate u_msi (
    .retire_i    (st_q == ST_END),
    .force_bit_i (d_q.cmd[CMD_FORCE]),
    .force_en_i  (force_msi_en_i),
    .resp_bit_i  (want_resp),
    .resp_en_i   (resp_msi_en_i),
    .msi_o       (msi_o)
  );

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_i && desc_ready_o) |=> !desc_ready_o); // R1
  AST_ONE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_start_o, sem_start_o, db_start_o})); // R2
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_start_o || sem_start_o || db_start_o) |=> !(dma_start_o || sem_start_o || db_start_o)); // R2
  AST_NO_START_BUSY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_ready_o |-> !(dma_start_o || sem_start_o || db_start_o || resp_valid_o)); // R1
  AST_DMA_TYPE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_start_o |-> (dma_dir_o == 2'd1 || dma_dir_o == 2'd2)); // R4
  AST_RESP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_ready_i) |=> (resp_valid_o && $stable(resp_id_o) && $stable(resp_code_o))); // R6
  AST_MSI_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_o |=> !msi_o); // R8
endmodule

// File: tb/dma_req_sequencer_tb.sv
`timescale 1ns/1ps
module dma_req_sequencer_tb;
  import dsq_pkg::*;

  typedef logic [167:0] ev_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_ni;
  logic               desc_valid_i;
  logic [DESC_W-1:0]  desc_i;
  logic               desc_ready_o;
  logic               force_msi_en_i, resp_msi_en_i;
  logic               dma_start_o, dma_bulk_o, dma_done_i;
  logic [1:0]         dma_dir_o;
  logic [ADDR_W-1:0]  dma_src_o, dma_dst_o;
  logic [LEN_W-1:0]   dma_len_o;
  logic               sem_start_o, sem_done_i;
  logic [SEM_W-1:0]   sem_cmd_o;
  logic               db_start_o, db_done_i;
  logic [ADDR_W-1:0]  db_addr_o;
  logic [31:0]        db_data_o;
  logic [1:0]         db_size_o;
  logic               resp_valid_o, resp_ready_i;
  logic [ID_W-1:0]    resp_id_o;
  logic [CODE_W-1:0]  resp_code_o;
  logic               msi_o;

  dma_req_sequencer u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .desc_valid_i(desc_valid_i), .desc_i(desc_i), .desc_ready_o(desc_ready_o),
    .force_msi_en_i(force_msi_en_i), .resp_msi_en_i(resp_msi_en_i),
    .dma_start_o(dma_start_o), .dma_dir_o(dma_dir_o), .dma_bulk_o(dma_bulk_o),
    .dma_src_o(dma_src_o), .dma_dst_o(dma_dst_o), .dma_len_o(dma_len_o),
    .dma_done_i(dma_done_i),
    .sem_start_o(sem_start_o), .sem_cmd_o(sem_cmd_o), .sem_done_i(sem_done_i),
    .db_start_o(db_start_o), .db_addr_o(db_addr_o), .db_data_o(db_data_o),
    .db_size_o(db_size_o), .db_done_i(db_done_i),
    .resp_valid_o(resp_valid_o), .resp_id_o(resp_id_o), .resp_code_o(resp_code_o),
    .resp_ready_i(resp_ready_i), .msi_o(msi_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  ev_t             exp_ev[8];
  int              exp_n;
  bit              exp_resp, exp_msi;
  logic [CODE_W-1:0] exp_code;

  task automatic chk(bit ok, string req, string what, ev_t act, ev_t exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic ev_t ev_dma(dsq_desc_t d);
    return {4'h1, 1'b0, d.cmd[CMD_BULK], d.cmd[1:0], d.src, d.dst, d.len};
  endfunction
  function automatic ev_t ev_sem(logic [31:0] w);
    return {8'h20, 64'd0, 64'd0, w};
  endfunction
  function automatic ev_t ev_bell(dsq_desc_t d);
    return {4'h3, 2'b00, d.bell_attr[1:0], d.bell_addr, 64'd0, d.bell_data};
  endfunction

  task automatic model(dsq_desc_t d, bit fen, bit ren);
    int npre = 0;
    logic [31:0] pw = '0;
    for (int k = 0; k < NSEM; k++)
      if (d.sem[k][31] && d.sem[k][22]) begin npre++; pw = d.sem[k]; end
    exp_code = (d.cmd[1:0] == 2'd3) ? 16'd1 : (npre > 1 ? 16'd2 : 16'd0);
    exp_n = 0;
    if (exp_code == 16'd0) begin
      if (npre == 1) begin exp_ev[exp_n] = ev_sem(pw); exp_n++; end
      if (d.cmd[1:0] != 2'd0) begin exp_ev[exp_n] = ev_dma(d); exp_n++; end
      for (int k = 0; k < NSEM; k++)
        if (d.sem[k][31] && !d.sem[k][22]) begin exp_ev[exp_n] = ev_sem(d.sem[k]); exp_n++; end
      if (d.bell_attr[7]) begin exp_ev[exp_n] = ev_bell(d); exp_n++; end
    end
    exp_resp = d.cmd[4];
    exp_msi  = (d.cmd[7] & fen) | (d.cmd[4] & ren);
  endtask

  task automatic run_desc(dsq_desc_t d, bit fen, bit ren, int rwait, string tag);
    int got_n = 0, msi_n = 0, pend = 0, cnt = 0, wl = rwait, starts;
    bit resp_seen = 0, done = 0;
    ev_t got;
    logic [ID_W-1:0] rid_s;
    logic [CODE_W-1:0] rc_s;
    string ctag;
    model(d, fen, ren);
    ctag = (exp_code == 16'd1) ? "R4" : ((exp_code == 16'd2) ? "R5" : "R6");
    force_msi_en_i = fen;
    resp_msi_en_i  = ren;
    @(negedge clk);
    chk(desc_ready_o, "R1", "ready before accept", ev_t'(desc_ready_o), 1);
    desc_i = d;
    desc_valid_i = 1'b1;
    @(negedge clk);
    desc_valid_i = 1'b0;
    chk(!desc_ready_o, "R1", "ready low after accept", ev_t'(desc_ready_o), 0);
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (desc_ready_o) begin done = 1; break; end
      dma_done_i = 0; sem_done_i = 0; db_done_i = 0; resp_ready_i = 0;
      if (pend != 0) begin
        if (cnt == 0) begin
          if (pend == 1) dma_done_i = 1;
          else if (pend == 2) sem_done_i = 1;
          else db_done_i = 1;
          pend = 0;
        end else cnt--;
      end
      starts = int'(dma_start_o) + int'(sem_start_o) + int'(db_start_o);
      if (starts > 1) chk(0, "R2", "overlapping starts", ev_t'(starts), 1);
      if (starts != 0) begin
        if (dma_start_o) begin
          got = {4'h1, 1'b0, dma_bulk_o, dma_dir_o, dma_src_o, dma_dst_o, dma_len_o};
          pend = 1;
        end else if (sem_start_o) begin
          got = {8'h20, 64'd0, 64'd0, sem_cmd_o};
          pend = 2;
        end else begin
          got = {4'h3, 2'b00, db_size_o, db_addr_o, 64'd0, db_data_o};
          pend = 3;
        end
        cnt = $urandom % 4;
        if (got_n < exp_n) chk(got == exp_ev[got_n], tag, "phase event", got, exp_ev[got_n]);
        else chk(0, (exp_code != 0) ? ctag : tag, "unexpected phase start", got, 0);
        got_n++;
      end
      if (resp_valid_o) begin
        if (!resp_seen) begin
          resp_seen = 1; rid_s = resp_id_o; rc_s = resp_code_o;
          chk(resp_id_o == d.rid, "R6", "response id", ev_t'(resp_id_o), ev_t'(d.rid));
          chk(resp_code_o == exp_code, ctag, "response code", ev_t'(resp_code_o), ev_t'(exp_code));
        end else if (resp_id_o != rid_s || resp_code_o != rc_s)
          chk(0, "R6", "response changed while stalled", ev_t'({resp_id_o, resp_code_o}), ev_t'({rid_s, rc_s}));
        if (wl == 0) resp_ready_i = 1; else wl--;
      end
      if (msi_o) msi_n++;
      @(negedge clk);
    end
    dma_done_i = 0; sem_done_i = 0; db_done_i = 0; resp_ready_i = 0;
    chk(done, "R1", "descriptor retired", ev_t'(done), 1);
    chk(got_n == exp_n, (exp_code != 0) ? ctag : tag, "phase count", ev_t'(got_n), ev_t'(exp_n));
    chk(resp_seen == exp_resp, exp_resp ? "R6" : "R7", "response presence", ev_t'(resp_seen), ev_t'(exp_resp));
    chk(msi_n == int'(exp_msi), "R8", "msi pulses", ev_t'(msi_n), ev_t'(exp_msi));
  endtask

  function automatic dsq_desc_t rand_desc();
    dsq_desc_t d;
    d.rid = ID_W'($urandom);
    d.seq = 8'($urandom);
    d.cmd = 8'($urandom);
    d.src = {$urandom, $urandom};
    d.dst = {$urandom, $urandom};
    d.len = $urandom;
    d.bell_addr = {$urandom, $urandom};
    d.bell_attr = 8'($urandom);
    d.bell_data = $urandom;
    for (int k = 0; k < NSEM; k++) begin
      d.sem[k] = $urandom;
      d.sem[k][22] = ($urandom % 5 == 0);
    end
    return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected retire");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    dsq_desc_t d, b;
    void'($urandom(32'h5eed_1234));
    rst_ni = 0; desc_valid_i = 0; desc_i = '0;
    force_msi_en_i = 0; resp_msi_en_i = 0;
    dma_done_i = 0; sem_done_i = 0; db_done_i = 0; resp_ready_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(desc_ready_o, "R1", "reset ready", ev_t'(desc_ready_o), 1);
    chk(!(dma_start_o | sem_start_o | db_start_o), "R2", "reset starts", ev_t'({dma_start_o, sem_start_o, db_start_o}), 0);
    chk(!resp_valid_o && !msi_o, "R8", "reset resp/msi", ev_t'({resp_valid_o, msi_o}), 0);

    // empty descriptor: no phases, no response (R2, R7)
    d = '0; d.rid = 16'h0101;
    run_desc(d, 1, 1, 0, "R2");

    // full bulk host-to-device: presync slot 2, postsync 0 and 3, doorbell, response
    b = rand_desc();
    b.cmd = 8'b0001_1001;
    b.sem[0][31] = 1; b.sem[0][22] = 0;
    b.sem[1][31] = 0;
    b.sem[2][31] = 1; b.sem[2][22] = 1;
    b.sem[3][31] = 1; b.sem[3][22] = 0;
    b.bell_attr = 8'h81;
    run_desc(b, 0, 0, 0, "R2");

    // R9: same descriptor, sequence and reserved command bits changed
    d = b; d.seq = ~b.seq; d.cmd[6] = 1; d.cmd[5] = 1; d.cmd[2] = 1;
    run_desc(d, 0, 0, 0, "R9");

    // linked-list device-to-host, doorbell 8-bit (R3, R10)
    d = b; d.cmd = 8'b0000_0010; d.bell_attr = 8'h82;
    run_desc(d, 0, 0, 0, "R3");
    d.bell_attr = 8'h80; d.cmd = 8'b0000_1001;
    run_desc(d, 0, 0, 0, "R10");

    // illegal type with response (R4)
    d = b; d.cmd = 8'b0001_0011;
    run_desc(d, 0, 1, 2, "R4");
    // two presyncs (R5)
    d = b; d.sem[0][22] = 1;
    run_desc(d, 0, 0, 1, "R5");
    // both errors: type wins (R4)
    d.cmd = 8'b0001_1011;
    run_desc(d, 0, 0, 0, "R4");

    // force bit with and without enable (R8)
    d = b; d.cmd = 8'b1000_1001;
    run_desc(d, 0, 1, 0, "R8");
    run_desc(d, 1, 0, 0, "R8");
    // response interrupt policy, stalled queue (R6, R8)
    d.cmd = 8'b0001_0001;
    run_desc(d, 0, 1, 6, "R6");
    run_desc(d, 1, 0, 3, "R8");
    // no response requested (R7)
    d.cmd = 8'b0000_0001;
    run_desc(d, 0, 1, 0, "R7");

    for (int i = 0; i < 80; i++) begin
      d = rand_desc();
      run_desc(d, 1'($urandom), 1'($urandom), $urandom % 4, "R2");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule